// File: doc/BRIEF.md
# Sequencer Instruction Dispatch Queues

This block sits between a real-time sequencer and the units that carry out its instructions. Each sequencer clock it can take one instruction that has already been decoded. The instruction carries a two-bit class code and an opaque payload. Three classes go into separate first-in-first-out queues: waveform playback, waveform prefetch, and wait/set.

The prefetch queue offers its head to the memory side whenever it holds an entry. The playback and wait/set queues offer their heads only while the timing unit holds the matching release line. The playback consumer keeps its ready signal low while an earlier waveform is still playing. Consecutive playbacks therefore start back to back, each as soon as the previous one ends.

The fourth class returns a value to the sequencer and is never queued. Once such an instruction is taken, the dispatcher closes its input. It waits until all three queues are empty, then issues the request. When the completion arrives it hands the returned value back to the sequencer, and it opens its input again one cycle after that hand-back.

Top module: `seq_dispatch`

## Requirements
- R1: At most one instruction is accepted per clock: an instruction is taken on a rising edge where `in_valid` and `in_ready` are both high. `in_ready` is high only while no value-returning instruction is outstanding and the destination queue of the offered class is not full.
- R2: Class code 2'b00 writes the payload to the playback queue, 2'b01 to the prefetch queue and 2'b10 to the wait/set queue. Each queue hands its entries out in arrival order, and an accepted entry shows at its queue head from the next cycle.
- R3: `pf_valid` is high in every cycle in which the prefetch queue holds an entry, whatever the release inputs are. The head leaves the queue on an edge with `pf_valid` and `pf_ready` both high.
- R4: `play_valid` is high only when the playback queue holds an entry and `rel_play` is high. The head leaves the queue on an edge with `play_valid` and `play_ready` both high. While `play_ready` stays high, entries leave on consecutive edges.
- R5: `ws_valid` is high only when the wait/set queue holds an entry and `rel_ws` is high. The head leaves the queue on an edge with `ws_valid` and `ws_ready` both high.
- R6: Class code 2'b11 is never queued. `get_req`, with its payload on `get_data`, is high only while that instruction is outstanding and all three queues are empty.
- R7: From the edge that accepts a class 2'b11 instruction until the cycle after its value is returned, `in_ready` is low for every class.
- R8: On an edge where `get_req` and `get_done` are both high, `get_value` is captured. In the next cycle only, `ret_valid` is high and `ret_value` carries the captured value. `get_done` in any other cycle has no effect.
- R9: Each queue holds 8 entries. While a queue is full, `in_ready` is low for that class only, and the other classes are still accepted.
- R10: A synchronous active-low reset empties all queues and cancels any outstanding value-returning instruction. After reset `in_ready` is high and every valid, `get_req` and `ret_valid` output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Instruction can be taken this cycle |
| in_class | input | 2 | Class code: 00 playback, 01 prefetch, 10 wait/set, 11 get |
| in_data | input | PW (16) | Instruction payload |
| rel_play | input | 1 | Timing-unit release for the playback queue |
| rel_ws | input | 1 | Timing-unit release for the wait/set queue |
| play_valid | output | 1 | Playback head offered |
| play_ready | input | 1 | Waveform player can start a playback |
| play_data | output | PW (16) | Playback head payload |
| pf_valid | output | 1 | Prefetch head offered |
| pf_ready | input | 1 | Memory side accepts a prefetch |
| pf_data | output | PW (16) | Prefetch head payload |
| ws_valid | output | 1 | Wait/set head offered |
| ws_ready | input | 1 | Wait/set consumer accepts |
| ws_data | output | PW (16) | Wait/set head payload |
| get_req | output | 1 | Value-returning request issued |
| get_data | output | PW (16) | Payload of the value-returning instruction |
| get_done | input | 1 | Value-returning request completed |
| get_value | input | RW (16) | Value returned by the request |
| ret_valid | output | 1 | Returned value presented to the sequencer |
| ret_value | output | RW (16) | Returned value |

## Verification
An accepted entry appears at its queue head one edge after acceptance. A head that is released and handshaken is gone from the next cycle. `get_req` rises in the first cycle in which the queues are empty after the stalling instruction was taken. `ret_valid` follows `get_done` by exactly one edge, and `in_ready` returns one cycle after that. The bench sets inputs just after the falling edge. It lets the combinational paths settle for a short delay, then compares every output with a behavioural queue model. The model advances on the rising edge using the same input values that were compared, so every result is checked in the very cycle it is due.

// File: rtl/disp_pkg.sv
// Package: shared class codes, queue indices and barrier states for the
// instruction dispatcher. Assumes the class code is two bits wide.
package disp_pkg;
    typedef enum logic [1:0] {
        CLS_PLAY = 2'b00,
        CLS_PREF = 2'b01,
        CLS_WS   = 2'b10,
        CLS_GET  = 2'b11
    } instr_cls_e;

    localparam int NUM_Q = 3;   // queued classes: codes 0..NUM_Q-1

    typedef enum logic [1:0] {
        BAR_IDLE   = 2'b00,
        BAR_DRAIN  = 2'b01,
        BAR_RETURN = 2'b10
    } barrier_st_e;
endpackage

// File: rtl/disp_fifo.sv
// disp_fifo: synchronous FIFO with a combinational head.
// Assumes the caller never pushes when full or pops when empty.
// A push and a pop in the same cycle are both performed.
module disp_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [CW-1:0] cnt;

    // Storage write: no reset needed, validity is tracked by cnt.
    always_ff @(posedge clk) begin
        if (push) mem[wp] <= din;
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + AW'(1);
            if (pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + AW'(1);
            cnt <= cnt + CW'(push) - CW'(pop);
        end
    end

    assign dout  = mem[rp];
    assign empty = (cnt == '0);
    assign full  = (cnt == CW'(DEPTH));
endmodule

// File: rtl/get_barrier.sv
// get_barrier: holds one value-returning instruction until every queue
// has drained, issues it, then returns the completion value for one cycle.
// Assumes get_accept is only raised while idle is high.
module get_barrier
    import disp_pkg::*;
#(
    parameter int PW = 16,
    parameter int RW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          get_accept,
    input  logic [PW-1:0] get_cmd,
    input  logic          all_empty,
    input  logic          get_done,
    input  logic [RW-1:0] get_value,
    output logic          idle,
    output logic          get_req,
    output logic [PW-1:0] get_data,
    output logic          ret_valid,
    output logic [RW-1:0] ret_value
);
    barrier_st_e   st;
    logic [PW-1:0] cmd_q;
    logic [RW-1:0] val_q;

    // Barrier sequencing: idle -> drain -> return -> idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st    <= BAR_IDLE;
            cmd_q <= '0;
            val_q <= '0;
        end else begin
            case (st)
                BAR_IDLE: if (get_accept) begin
                    st    <= BAR_DRAIN;
                    cmd_q <= get_cmd;
                end
                BAR_DRAIN: if (all_empty && get_done) begin
                    st    <= BAR_RETURN;
                    val_q <= get_value;
                end
                BAR_RETURN: st <= BAR_IDLE;
                default:    st <= BAR_IDLE;
            endcase
        end
    end

    assign idle      = (st == BAR_IDLE);
    assign get_req   = (st == BAR_DRAIN) && all_empty;
    assign get_data  = cmd_q;
    assign ret_valid = (st == BAR_RETURN);
    assign ret_value = val_q;
endmodule

// File: rtl/seq_dispatch.sv
// seq_dispatch: sorts one decoded instruction per clock into playback,
// prefetch and wait/set queues, and runs value-returning instructions
// behind a full drain barrier. Assumes in_class is stable while in_valid.
module seq_dispatch
    import disp_pkg::*;
#(
    parameter int PW     = 16,
    parameter int RW     = 16,
    parameter int QDEPTH = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [1:0]    in_class,
    input  logic [PW-1:0] in_data,
    input  logic          rel_play,
    input  logic          rel_ws,
    output logic          play_valid,
    input  logic          play_ready,
    output logic [PW-1:0] play_data,
    output logic          pf_valid,
    input  logic          pf_ready,
    output logic [PW-1:0] pf_data,
    output logic          ws_valid,
    input  logic          ws_ready,
    output logic [PW-1:0] ws_data,
    output logic          get_req,
    output logic [PW-1:0] get_data,
    input  logic          get_done,
    input  logic [RW-1:0] get_value,
    output logic          ret_valid,
    output logic [RW-1:0] ret_value
);
    logic [NUM_Q-1:0] q_push, q_pop, q_empty, q_full;
    logic [PW-1:0]    q_head [NUM_Q];
    logic             accept, dest_full, bar_idle, get_accept;

    // Queue instances, one per queued class; index equals class code.
    for (genvar q = 0; q < NUM_Q; q++) begin : g_q
        assign q_push[q] = accept && (in_class == 2'(q));
        disp_fifo #(.W(PW), .DEPTH(QDEPTH)) u_fifo (
            .clk(clk), .rst_n(rst_n),
            .push(q_push[q]), .din(in_data),
            .pop(q_pop[q]), .dout(q_head[q]),
            .empty(q_empty[q]), .full(q_full[q])
        );
    end

    // Destination-full lookup for the offered class.
    always_comb begin
        case (in_class)
            CLS_PLAY: dest_full = q_full[0];
            CLS_PREF: dest_full = q_full[1];
            CLS_WS:   dest_full = q_full[2];
            default:  dest_full = 1'b0;
        endcase
    end

    assign in_ready   = bar_idle && !dest_full;
    assign accept     = in_valid && in_ready;
    assign get_accept = accept && (in_class == CLS_GET);

    // Head release: timing-unit gated for playback and wait/set only.
    assign play_valid = !q_empty[0] && rel_play;
    assign pf_valid   = !q_empty[1];
    assign ws_valid   = !q_empty[2] && rel_ws;
    assign q_pop[0]   = play_valid && play_ready;
    assign q_pop[1]   = pf_valid && pf_ready;
    assign q_pop[2]   = ws_valid && ws_ready;
    assign play_data  = q_head[0];
    assign pf_data    = q_head[1];
    assign ws_data    = q_head[2];

    get_barrier #(.PW(PW), .RW(RW)) u_bar (
        .clk(clk), .rst_n(rst_n),
        .get_accept(get_accept), .get_cmd(in_data),
        .all_empty(&q_empty), .get_done(get_done), .get_value(get_value),
        .idle(bar_idle), .get_req(get_req), .get_data(get_data),
        .ret_valid(ret_valid), .ret_value(ret_value)
    );
endmodule

// File: rtl/disp_checker.sv
// disp_checker: protocol properties for seq_dispatch, attached by bind.
// Observes ports plus the per-queue empty/full flags.
module disp_checker #(
    parameter int NQ = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic          in_ready,
    input logic [1:0]    in_class,
    input logic          rel_play,
    input logic          rel_ws,
    input logic          play_valid,
    input logic          pf_valid,
    input logic          ws_valid,
    input logic          get_req,
    input logic          ret_valid,
    input logic [NQ-1:0] q_empty,
    input logic [NQ-1:0] q_full
);
    a_r3_prefetch_free: assert property (@(posedge clk) disable iff (!rst_n)
        !q_empty[1] |-> pf_valid);
    a_r4_play_gated: assert property (@(posedge clk) disable iff (!rst_n)
        play_valid |-> rel_play && !q_empty[0]);
    a_r5_ws_gated: assert property (@(posedge clk) disable iff (!rst_n)
        ws_valid |-> rel_ws && !q_empty[2]);
    a_r6_get_after_drain: assert property (@(posedge clk) disable iff (!rst_n)
        get_req |-> (q_empty == '1));
    a_r7_stall_on_get: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_class == 2'b11) |=> !in_ready);
    a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        ret_valid |=> !ret_valid);
    a_r8_return_closed: assert property (@(posedge clk) disable iff (!rst_n)
        ret_valid |-> !in_ready);
    a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        q_full[0] |-> !(in_valid && in_ready && in_class == 2'b00));
endmodule

bind seq_dispatch disp_checker #(.NQ(3)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_class(in_class), .rel_play(rel_play), .rel_ws(rel_ws),
    .play_valid(play_valid), .pf_valid(pf_valid), .ws_valid(ws_valid),
    .get_req(get_req), .ret_valid(ret_valid),
    .q_empty(q_empty), .q_full(q_full)
);

// File: tb/seq_dispatch_tb.sv
// Bench for seq_dispatch: behavioural queue model compared every cycle.
module seq_dispatch_tb_top;
    localparam int PW = 16, RW = 16, DEPTH = 8;

    logic clk = 0, rst_n = 0;
    logic in_valid = 0, rel_play = 0, rel_ws = 0;
    logic play_ready = 0, pf_ready = 0, ws_ready = 0, get_done = 0;
    logic [1:0] in_class = 0;
    logic [PW-1:0] in_data = 0;
    logic [RW-1:0] get_value = 0;
    logic in_ready, play_valid, pf_valid, ws_valid, get_req, ret_valid;
    logic [PW-1:0] play_data, pf_data, ws_data, get_data;
    logic [RW-1:0] ret_value;

    always #4 clk = ~clk;   // 125 MHz

    seq_dispatch #(.PW(PW), .RW(RW), .QDEPTH(DEPTH)) dut_i (.*);

    int checks = 0, fails = 0, cyc = 0;
    int qp[$], qf[$], qw[$];
    int mode = 0;           // 0 idle, 1 waiting for drain/done, 2 returning
    int m_cmd = 0, m_val = 0;

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s cycle %0d: actual %0h expected %0h", tag, cyc, act, exp);
        end
    endtask

    function automatic int qsize(int c);
        if (c == 0) return qp.size();
        if (c == 1) return qf.size();
        return qw.size();
    endfunction

    // One clock: compare settled outputs, then advance the model on the edge.
    task automatic step();
        bit e_rdy, e_pv, e_fv, e_wv, e_gr, e_rv, acc;
        #1;
        e_rdy = (mode == 0) && (in_class == 2'd3 || qsize(int'(in_class)) < DEPTH);
        e_pv  = qp.size() > 0 && rel_play;
        e_fv  = qf.size() > 0;
        e_wv  = qw.size() > 0 && rel_ws;
        e_gr  = mode == 1 && qp.size() == 0 && qf.size() == 0 && qw.size() == 0;
        e_rv  = mode == 2;
        if (rst_n) begin
            chk("R1/R7/R9 in_ready", int'(in_ready), int'(e_rdy));
            chk("R4 play_valid", int'(play_valid), int'(e_pv));
            if (e_pv) chk("R2 play_data", int'(play_data), qp[0]);
            chk("R3 pf_valid", int'(pf_valid), int'(e_fv));
            if (e_fv) chk("R2 pf_data", int'(pf_data), qf[0]);
            chk("R5 ws_valid", int'(ws_valid), int'(e_wv));
            if (e_wv) chk("R2 ws_data", int'(ws_data), qw[0]);
            chk("R6 get_req", int'(get_req), int'(e_gr));
            if (e_gr) chk("R6 get_data", int'(get_data), m_cmd);
            chk("R8 ret_valid", int'(ret_valid), int'(e_rv));
            if (e_rv) chk("R8 ret_value", int'(ret_value), m_val);
        end
        acc = in_valid && e_rdy;
        @(posedge clk);
        cyc++;
        if (!rst_n) begin
            qp.delete(); qf.delete(); qw.delete(); mode = 0;
        end else begin
            if (e_pv && play_ready) void'(qp.pop_front());
            if (e_fv && pf_ready)   void'(qf.pop_front());
            if (e_wv && ws_ready)   void'(qw.pop_front());
            if (mode == 2) mode = 0;
            else if (mode == 1 && e_gr && get_done) begin mode = 2; m_val = int'(get_value); end
            if (acc) begin
                case (in_class)
                    2'd0: qp.push_back(int'(in_data));
                    2'd1: qf.push_back(int'(in_data));
                    2'd2: qw.push_back(int'(in_data));
                    default: begin mode = 1; m_cmd = int'(in_data); end
                endcase
            end
        end
        @(negedge clk);
    endtask

    task automatic offer(bit v, int c, int d);
        in_valid = v; in_class = 2'(c); in_data = PW'(d);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        @(negedge clk);
        repeat (3) step();
        rst_n = 1;
        // R10: reset state
        #1;
        chk("R10 in_ready after reset", int'(in_ready), 1);
        chk("R10 no valids after reset", int'(play_valid | pf_valid | ws_valid | get_req | ret_valid), 0);
        // R9: fill playback, no release; other class still accepted
        for (int i = 0; i < 9; i++) begin offer(1, 0, 16'h100 + i); step(); end
        chk("R9 full playback blocks", int'(in_ready), 0);
        offer(1, 2, 16'h200); step();
        offer(0, 0, 0); step();
        // R4: release with player busy, then back to back
        rel_play = 1; play_ready = 0; repeat (3) step();
        play_ready = 1; repeat (10) step();
        // R5: wait/set only released by rel_ws
        ws_ready = 1; step(); rel_ws = 1; repeat (2) step();
        // R3: prefetch drains without release
        rel_play = 0; rel_ws = 0; pf_ready = 1;
        for (int i = 0; i < 4; i++) begin offer(1, 1, 16'h300 + i); step(); end
        offer(0, 0, 0); repeat (3) step();
        // R6/R7/R8: get behind pending playback and wait/set entries
        offer(1, 0, 16'h400); step();
        offer(1, 2, 16'h500); step();
        offer(1, 3, 16'h600); step();
        offer(1, 1, 16'h700); get_value = 16'hbeef; get_done = 1; repeat (3) step();
        rel_play = 1; rel_ws = 1; repeat (3) step();
        get_done = 0; repeat (2) step();
        get_done = 1; repeat (4) step();
        get_done = 0; offer(0, 0, 0); step();
        // R10: reset with queued entries and a pending get
        rel_play = 0; rel_ws = 0; pf_ready = 0;
        offer(1, 0, 16'h800); step(); offer(1, 3, 16'h900); step();
        offer(0, 0, 0); rst_n = 0; step(); rst_n = 1;
        #1;
        chk("R10 reset clears queues", int'(play_valid | pf_valid | get_req), 0);
        chk("R10 reset clears stall", int'(in_ready), 1);
        // Mixed traffic
        for (int i = 0; i < 3000; i++) begin
            offer(($urandom % 3) != 0, int'($urandom % 8 == 0 ? 3 : $urandom % 3), int'($urandom & 16'hffff));
            rel_play = $urandom % 2; rel_ws = $urandom % 3 != 0;
            play_ready = $urandom % 4 != 0; pf_ready = $urandom % 2;
            ws_ready = $urandom % 2; get_done = $urandom % 3 == 0;
            get_value = RW'($urandom);
            step();
        end
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule